// File: doc/BRIEF.md
# Secure Coprocessor Access Controller

This block decides, for every coprocessor instruction, whether the instruction may run or must take an undefined-instruction trap. It holds two control registers. The delegation register has one enable bit per coprocessor 0 to 13 and is owned by the secure side. The permission register has a 2-bit access field per coprocessor. Given the coprocessor number, the requester's security state and whether it is privileged, the block returns allow or trap combinationally from the current register contents.

Both registers are written and read over a simple register port that carries the requester's security state and privilege level (0 user, 1 kernel, 2 hypervisor, 3 monitor). A non-secure write to the permission register only changes the fields that the secure side has delegated; the other fields keep their value. Non-secure use of a coprocessor is refused outright unless its delegation bit is set, before the permission field is even looked at. Coprocessors 14 and 15 are not controlled here and always pass.

Top module: `cop_access_guard`

## Requirements
- R1: The delegation register holds 14 bits, bit n enabling non-secure use of coprocessor n (0 to 13); bits 31:14 of a write are dropped and always read back as zero.
- R2: After a synchronous reset both registers read zero and every check of coprocessors 0 to 13 traps.
- R3: The delegation register (wr_sel/rd_sel = 0) is written only at level 3 and read only at levels 2 and 3; any other attempt leaves it unchanged, returns zero read data and pulses acc_err.
- R4: The permission register (wr_sel/rd_sel = 1) gives coprocessor n the field at bits [2n+1:2n].
- R5: A permission write is first ANDed with the implemented-field mask: bits 31:28 are always cleared and bits 23:20 (coprocessors 10 and 11) are kept only when HAS_FPU is 1.
- R6: A permission write with wr_nonsec = 1 updates only the fields whose delegation bit is set; all other fields keep their value.
- R7: A check with chk_nonsec = 1 for a coprocessor whose delegation bit is clear traps, whatever its field holds.
- R8: A field value of 0 or 2 traps.
- R9: A field value of 1 allows only privileged checks (chk_priv = 1); a value of 3 allows both privileged and unprivileged checks.
- R10: A check for coprocessor 14 or 15 is always allowed.
- R11: The permission register is written and read at levels 1 to 3; a level 0 attempt is ignored, returns zero read data and pulses acc_err.
- R12: chk_allow follows the register contents combinationally; a register write is seen by checks from the next clock cycle, and rd_data and acc_err appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 1 | Target register: 0 delegation, 1 permission |
| wr_data | input | 32 | Write data |
| wr_nonsec | input | 1 | Writer is in non-secure state |
| wr_level | input | 2 | Writer privilege level (0 user .. 3 monitor) |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | Register to read: 0 delegation, 1 permission |
| rd_level | input | 2 | Reader privilege level |
| rd_data | output | 32 | Registered read data, zero when refused |
| acc_err | output | 1 | One-cycle pulse for a refused read or write |
| chk_cp | input | 4 | Coprocessor number of the instruction |
| chk_nonsec | input | 1 | Instruction issued in non-secure state |
| chk_priv | input | 1 | Instruction issued at a privileged level |
| chk_allow | output | 1 | 1 allow, 0 undefined trap |

## Verification
On every cycle the assertions check the reset clearing, that refused writes leave the registers untouched and raise the error pulse, that non-secure permission writes never disturb undelegated fields, that the non-secure gate traps undelegated coprocessors, and that coprocessors 14 and 15 always pass. The exact decoding of every field value against privilege, the implemented-field masking with and without the floating-point unit, the upper-bit dropping of the delegation register and the one-cycle visibility of a write can only be shown by the bench's scenarios with known register contents.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  localparam logic SEL_DELEG = 1'b0;
  localparam logic SEL_PERM  = 1'b1;

  localparam logic [1:0] FLD_PRIV_ONLY = 2'd1;
  localparam logic [1:0] FLD_FULL      = 2'd3;
endpackage

// File: rtl/cag_regs.sv
module cag_regs
  import cag_pkg::*;
#(
  parameter int NUM_CP    = 14,
  parameter int DATA_W    = 32,
  parameter bit HAS_FPU   = 1'b1,
  parameter int FPU_CP_LO = 10,
  parameter int FPU_CP_HI = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_nonsec,
  input  logic [1:0]        wr_level,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [1:0]        rd_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic [NUM_CP-1:0] deleg_o,
  output logic [DATA_W-1:0] perm_o
);
  function automatic logic [DATA_W-1:0] build_impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CP; i++) begin
      if (HAS_FPU || (i != FPU_CP_LO && i != FPU_CP_HI)) m[2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = build_impl_mask();

  logic [NUM_CP-1:0] deleg_q;
  logic [DATA_W-1:0] perm_q;
  logic [DATA_W-1:0] ns_mask;
  logic [DATA_W-1:0] perm_next;
  logic              deleg_wr_ok, perm_wr_ok, wr_bad, rd_ok, rd_bad;
  lvl_e              wlvl, rlvl;

  assign wlvl = lvl_e'(wr_level);
  assign rlvl = lvl_e'(rd_level);

  assign deleg_wr_ok = wr_en && (wr_sel == SEL_DELEG) && (wlvl == LVL_MON);
  assign perm_wr_ok  = wr_en && (wr_sel == SEL_PERM) && (wlvl != LVL_USER);
  assign wr_bad      = wr_en && !deleg_wr_ok && !perm_wr_ok;
  assign rd_ok       = (rd_sel == SEL_DELEG) ? (rlvl == LVL_HYP || rlvl == LVL_MON)
                                             : (rlvl != LVL_USER);
  assign rd_bad      = rd_en && !rd_ok;

  always_comb begin
    ns_mask = '0;
    for (int i = 0; i < NUM_CP; i++) ns_mask[2*i +: 2] = {2{deleg_q[i]}};
  end

  always_comb begin
    perm_next = wr_data & IMPL_MASK;
    if (wr_nonsec) perm_next = (perm_next & ns_mask) | (perm_q & ~ns_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deleg_q <= '0;
      perm_q  <= '0;
      rd_data <= '0;
      acc_err <= 1'b0;
    end else begin
      if (deleg_wr_ok) deleg_q <= wr_data[NUM_CP-1:0];
      if (perm_wr_ok)  perm_q  <= perm_next;
      acc_err <= wr_bad || rd_bad;
      if (rd_en && rd_ok)
        rd_data <= (rd_sel == SEL_DELEG) ? DATA_W'(deleg_q) : perm_q;
      else
        rd_data <= '0;
    end
  end

  assign deleg_o = deleg_q;
  assign perm_o  = perm_q;

  // R2: reset clears both registers
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (deleg_q == '0 && perm_q == '0));

  // R3: delegation register untouched by non-monitor writes, error raised
  a_r3_deleg_guard: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_DELEG && wr_level != 2'd3) |=> ($stable(deleg_q) && acc_err));

  // R11: user-level permission writes ignored, error raised
  a_r11_user_perm_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_PERM && wr_level == 2'd0) |=> ($stable(perm_q) && acc_err));

  // R6: non-secure write keeps every undelegated field
  a_r6_ns_merge: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en && wr_nonsec && wr_sel == SEL_PERM))
      |-> ((perm_q & ~$past(ns_mask)) == ($past(perm_q) & ~$past(ns_mask))));
endmodule

// File: rtl/cag_check.sv
module cag_check
  import cag_pkg::*;
#(
  parameter int NUM_CP = 14,
  parameter int DATA_W = 32,
  parameter int CP_W   = 4
) (
  input  logic [NUM_CP-1:0] deleg,
  input  logic [DATA_W-1:0] perm,
  input  logic [CP_W-1:0]   cp,
  input  logic              nonsec,
  input  logic              priv,
  output logic              allow
);
  localparam int EXT_W = 1 << CP_W;

  logic [EXT_W-1:0] deleg_ext;
  logic [1:0]       fld;
  logic             in_range;

  assign deleg_ext = EXT_W'(deleg);
  assign in_range  = (int'(cp) < NUM_CP);
  assign fld       = perm[{cp, 1'b0} +: 2];

  always_comb begin
    if (!in_range)                   allow = 1'b1;
    else if (nonsec && !deleg_ext[cp]) allow = 1'b0;
    else begin
      case (fld)
        FLD_FULL:      allow = 1'b1;
        FLD_PRIV_ONLY: allow = priv;
        default:       allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cop_access_guard.sv
module cop_access_guard
  import cag_pkg::*;
#(
  parameter int NUM_CP  = 14,
  parameter int DATA_W  = 32,
  parameter int CP_W    = 4,
  parameter bit HAS_FPU = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_nonsec,
  input  logic [1:0]        wr_level,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [1:0]        rd_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  input  logic [CP_W-1:0]   chk_cp,
  input  logic              chk_nonsec,
  input  logic              chk_priv,
  output logic              chk_allow
);
  localparam int EXT_W = 1 << CP_W;

  logic [NUM_CP-1:0] deleg;
  logic [DATA_W-1:0] perm;
  logic [EXT_W-1:0]  deleg_ext;

  cag_regs #(
    .NUM_CP(NUM_CP), .DATA_W(DATA_W), .HAS_FPU(HAS_FPU)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_nonsec(wr_nonsec), .wr_level(wr_level),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_level(rd_level),
    .rd_data(rd_data), .acc_err(acc_err),
    .deleg_o(deleg), .perm_o(perm)
  );

  cag_check #(
    .NUM_CP(NUM_CP), .DATA_W(DATA_W), .CP_W(CP_W)
  ) u_check (
    .deleg(deleg), .perm(perm), .cp(chk_cp),
    .nonsec(chk_nonsec), .priv(chk_priv), .allow(chk_allow)
  );

  assign deleg_ext = EXT_W'(deleg);

  // R7: non-secure checks of undelegated coprocessors always trap
  a_r7_ns_gate: assert property (@(posedge clk) disable iff (rst)
    (chk_nonsec && int'(chk_cp) < NUM_CP && !deleg_ext[chk_cp]) |-> !chk_allow);

  // R10: coprocessors outside the controlled range always pass
  a_r10_passthrough: assert property (@(posedge clk) disable iff (rst)
    (int'(chk_cp) >= NUM_CP) |-> chk_allow);

  // R1: delegation read never returns bits above the implemented range
  a_r1_deleg_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en && rd_sel == SEL_DELEG)) |-> (rd_data[DATA_W-1:NUM_CP] == '0));
endmodule

// File: tb/cop_access_guard_tb.sv
module cop_access_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_nonsec = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_level = '0;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [1:0]  rd_level = '0;
  logic [31:0] rd_data, rd_data_nf;
  logic        acc_err, acc_err_nf;
  logic [3:0]  chk_cp = '0;
  logic        chk_nonsec = 1'b0, chk_priv = 1'b0;
  logic        chk_allow, chk_allow_nf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cop_access_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_nonsec(wr_nonsec), .wr_level(wr_level), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_level(rd_level), .rd_data(rd_data), .acc_err(acc_err),
    .chk_cp(chk_cp), .chk_nonsec(chk_nonsec), .chk_priv(chk_priv), .chk_allow(chk_allow)
  );

  cop_access_guard #(.HAS_FPU(1'b0)) u_nofpu (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_nonsec(wr_nonsec), .wr_level(wr_level), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_level(rd_level), .rd_data(rd_data_nf), .acc_err(acc_err_nf),
    .chk_cp(chk_cp), .chk_nonsec(chk_nonsec), .chk_priv(chk_priv), .chk_allow(chk_allow_nf)
  );

  // {cp[3:0], nonsec, priv, expected_allow}
  // deleg = 0x040B (cp0,1,3,10); fields: cp0=3 cp1=1 cp2=2 cp3=0 cp4=3 cp10=1 cp11=3
  localparam logic [6:0] VEC [16] = '{
    {4'd0,  1'b0, 1'b0, 1'b1},  // R9 field 3 unpriv
    {4'd0,  1'b1, 1'b0, 1'b1},  // R7 delegated
    {4'd1,  1'b0, 1'b1, 1'b1},  // R9 field 1 priv
    {4'd1,  1'b0, 1'b0, 1'b0},  // R9 field 1 unpriv
    {4'd1,  1'b1, 1'b1, 1'b1},  // R7 delegated priv
    {4'd2,  1'b0, 1'b1, 1'b0},  // R8 field 2
    {4'd3,  1'b0, 1'b1, 1'b0},  // R8 field 0
    {4'd4,  1'b0, 1'b0, 1'b1},  // R4 field 3 at bits 9:8
    {4'd4,  1'b1, 1'b1, 1'b0},  // R7 undelegated
    {4'd10, 1'b1, 1'b1, 1'b1},  // R4 field 1 at bits 21:20
    {4'd10, 1'b1, 1'b0, 1'b0},  // R9
    {4'd11, 1'b1, 1'b1, 1'b0},  // R7 undelegated
    {4'd11, 1'b0, 1'b0, 1'b1},  // R4 field 3 at bits 23:22
    {4'd14, 1'b1, 1'b0, 1'b1},  // R10
    {4'd15, 1'b1, 1'b0, 1'b1},  // R10
    {4'd5,  1'b0, 1'b1, 1'b0}   // R8 field 0
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [31:0] data,
                          input logic ns, input logic [1:0] lvl);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_nonsec = ns; wr_level = lvl;
    @(negedge clk);
    wr_en = 1'b0; wr_nonsec = 1'b0;
  endtask

  task automatic do_read(input logic sel, input logic [1:0] lvl,
                         output logic [31:0] data, output logic err);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel; rd_level = lvl;
    @(negedge clk);
    data = rd_data; err = acc_err;
    rd_en = 1'b0;
  endtask

  task automatic set_chk(input logic [3:0] cp, input logic ns, input logic pv);
    chk_cp = cp; chk_nonsec = ns; chk_priv = pv;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    do_read(1'b0, 2'd3, d, e);  check("R2 deleg reset", d, 32'h0);
    check("R2 no error", {31'b0, e}, 32'h0);
    do_read(1'b1, 2'd3, d, e);  check("R2 perm reset", d, 32'h0);
    set_chk(4'd0, 1'b0, 1'b1);  check("R2 trap after reset", {31'b0, chk_allow}, 32'h0);

    // R5 implemented-field mask, with and without FPU
    do_write(1'b1, 32'hFFFF_FFFF, 1'b0, 2'd1);
    check("R11 kernel write no error", {31'b0, acc_err}, 32'h0);
    do_read(1'b1, 2'd1, d, e);
    check("R5 mask with fpu", d, 32'h0FFF_FFFF);
    check("R5 mask without fpu", rd_data_nf, 32'h0F0F_FFFF);

    // R1 upper bits of delegation dropped
    do_write(1'b0, 32'hFFFF_FFFF, 1'b0, 2'd3);
    do_read(1'b0, 2'd3, d, e);  check("R1 deleg width", d, 32'h0000_3FFF);

    // R4 layout setup
    do_write(1'b0, 32'h0000_040B, 1'b0, 2'd3);
    do_write(1'b1, 32'hF0D0_0327, 1'b0, 2'd3);
    do_read(1'b1, 2'd3, d, e);  check("R4 perm stored", d, 32'h00D0_0327);

    // Vector table: R4 R7 R8 R9 R10
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      set_chk(VEC[i][6:3], VEC[i][2], VEC[i][1]);
      check($sformatf("R7/R8/R9/R10 vector %0d", i), {31'b0, chk_allow}, {31'b0, VEC[i][0]});
    end

    // R3 delegation register privilege
    do_write(1'b0, 32'h0, 1'b0, 2'd2);
    check("R3 hyp write error", {31'b0, acc_err}, 32'h1);
    do_read(1'b0, 2'd2, d, e);
    check("R3 hyp read value", d, 32'h0000_040B);
    check("R3 hyp read no error", {31'b0, e}, 32'h0);
    do_read(1'b0, 2'd1, d, e);
    check("R3 kernel read zero", d, 32'h0);
    check("R3 kernel read error", {31'b0, e}, 32'h1);

    // R11 permission register at user level
    do_write(1'b1, 32'h0, 1'b0, 2'd0);
    check("R11 user write error", {31'b0, acc_err}, 32'h1);
    do_read(1'b1, 2'd1, d, e);  check("R11 perm unchanged", d, 32'h00D0_0327);
    do_read(1'b1, 2'd0, d, e);
    check("R11 user read zero", d, 32'h0);
    check("R11 user read error", {31'b0, e}, 32'h1);

    // R6 non-secure merge
    do_write(1'b1, 32'hFFFF_FFFF, 1'b1, 2'd1);
    do_read(1'b1, 2'd1, d, e);  check("R6 merged perm", d, 32'h00F0_03EF);
    set_chk(4'd3, 1'b1, 1'b0);  check("R6 cp3 now full", {31'b0, chk_allow}, 32'h1);
    set_chk(4'd2, 1'b0, 1'b1);  check("R6 cp2 kept", {31'b0, chk_allow}, 32'h0);

    // R12 write visible on the next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h00F0_03FF; wr_nonsec = 1'b0; wr_level = 2'd1;
    set_chk(4'd2, 1'b0, 1'b1);
    check("R12 before edge", {31'b0, chk_allow}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R12 after edge", {31'b0, chk_allow}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule